// File: doc/BRIEF.md
# Serial receive hub

This block is the receive half of an asynchronous serial port. It samples the incoming line sixteen times per bit period, where one sample period is a programmable number of clocks. It takes a majority vote at each bit centre and rebuilds frames of five to eight data bits, with optional even or odd parity and one or two stop bits. A completed character is written into a receive FIFO only after its last stop bit has run its full length. Software drains the FIFO through a pop port that shows the head entry and the current fill count.

Five interrupt sources report on the receive side: FIFO fill threshold, idle timeout, framing error, parity error and break. Each one latches into a raw status bit that a write-one pulse clears. An enable mask selects which bits reach the interrupt line. A ready-to-receive output tells the far end to pause once the FIFO reaches a second threshold. A select input replaces the external line with an internal transmit signal, so the path can be tested without wiring.

Top module: `serial_rx_hub`

## Requirements
- R1: `fifo_cnt_o` rises by one for a good frame only once the final stop bit has completed. At the stop-bit centre the count still holds its old value.
- R2: `cfg_dlen_i` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive LSB first and the unused upper bits of `pop_data_o` read zero.
- R3: In `cfg_par_i`, bit 1 enables a parity bit after the data and bit 0 chooses odd (1) or even (0). A mismatch sets `int_raw_o[3]` and the character is still stored.
- R4: `cfg_stop_i[1]` = 1 selects two stop bits; values 0 and 1 select one. A stop bit sampled low sets `int_raw_o[2]` and the character is still stored.
- R5: A frame whose start, data, parity and stop samples are all low is a break. It sets `int_raw_o[4]`, stores nothing, and the receiver waits for a high line before it looks for the next start.
- R6: There are 16 samples per bit and one sample every `cfg_div_i` clocks (0 counts as 1). A start edge that is no longer low by majority at mid-bit is discarded.
- R7: `int_raw_o[0]` is set while `cfg_full_thr_i` is nonzero and `fifo_cnt_o` is at or above it.
- R8: When `cfg_tout_en_i` is set and `cfg_tout_thr_i` is nonzero, `int_raw_o[1]` is set after `cfg_tout_thr_i` units of 8 bit periods of idle receiver with a non-empty FIFO. The count restarts on every start bit and whenever the FIFO is empty.
- R9: `rts_o` is low when `cfg_flow_en_i` is set and `fifo_cnt_o` is at or above `cfg_flow_thr_i`. Otherwise it is high.
- R10: The raw status bits are sticky until a 1 on the matching `int_clr_i` bit (a new event wins). `int_st_o` = raw AND `int_ena_i`, and `irq_o` is the OR of `int_st_o`.
- R11: While `cfg_fifo_rst_i` is high the FIFO is empty and incoming characters are dropped. A pop on an empty FIFO has no effect.
- R12: With `lb_en_i` high the receiver takes `lb_tx_i` and ignores `rx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | External serial line |
| lb_en_i | input | 1 | Loopback select |
| lb_tx_i | input | 1 | Internal transmit line used in loopback |
| cfg_div_i | input | DIV_W | Clocks per sample (16 samples per bit) |
| cfg_dlen_i | input | 2 | Data length code |
| cfg_par_i | input | 2 | Parity enable (bit 1) and odd select (bit 0) |
| cfg_stop_i | input | 2 | Stop-bit code |
| cfg_full_thr_i | input | CNT_W | Fill threshold for the full interrupt |
| cfg_flow_en_i | input | 1 | Flow-control enable |
| cfg_flow_thr_i | input | CNT_W | Fill level that drops `rts_o` |
| cfg_tout_en_i | input | 1 | Timeout enable |
| cfg_tout_thr_i | input | TOUT_W | Timeout in units of 8 bit periods |
| cfg_fifo_rst_i | input | 1 | FIFO flush while high |
| pop_i | input | 1 | Remove head entry |
| pop_data_o | output | 8 | Head entry |
| fifo_cnt_o | output | CNT_W | FIFO occupancy |
| rts_o | output | 1 | Ready to receive |
| int_ena_i | input | 5 | Interrupt enable mask |
| int_clr_i | input | 5 | Write-one-to-clear pulses |
| int_raw_o | output | 5 | Raw status: 0 full, 1 timeout, 2 framing, 3 parity, 4 break |
| int_st_o | output | 5 | Masked status |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest things to reach are the timing windows: the gap between the stop-bit centre and the end of the stop bit, where the count must not yet have moved, and the idle timeout. The timeout only fires after a long idle stretch with data left in the FIFO, and it must stay quiet once the FIFO is empty. The bench samples the count at the stop-bit centre and again just after the frame, and it leaves three characters in the FIFO with popping suspended. It then checks the timeout flag before and after the programmed window, drains the FIFO and waits again. Telling a break from a framing error requires a line that stays low through the whole frame, so the bench drives twelve low bit periods as a break and separately sends a normal character whose stop bit is forced low.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int OS_RATE   = 16;
  localparam int OS_W      = $clog2(OS_RATE);
  localparam int VOTE_A    = OS_RATE / 2 - 2;
  localparam int VOTE_B    = OS_RATE / 2 - 1;
  localparam int VOTE_C    = OS_RATE / 2;
  localparam int UNIT_BITS = 8;
  localparam int IRQ_N     = 5;
  localparam int IRQ_FULL  = 0;
  localparam int IRQ_TOUT  = 1;
  localparam int IRQ_FRM   = 2;
  localparam int IRQ_PAR   = 3;
  localparam int IRQ_BRK   = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAIT_HI
  } frm_state_e;
endpackage

// File: rtl/srx_tick.sv
module srx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim    = (div_i == '0) ? '0 : div_i - 1'b1;
    tick_o = (cnt_q >= lim);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/srx_line.sv
module srx_line #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  input  logic lb_en_i,
  input  logic lb_i,
  output logic line_o
);
  logic [STAGES-1:0] rx_q, lb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '1;
      lb_q <= '1;
    end else begin
      rx_q <= {rx_q[STAGES-2:0], rx_i};
      lb_q <= {lb_q[STAGES-2:0], lb_i};
    end
  end

  assign line_o = lb_en_i ? lb_q[STAGES-1] : rx_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic [1:0] cfg_dlen_i,
  input  logic [1:0] cfg_par_i,
  input  logic [1:0] cfg_stop_i,
  output logic       push_o,
  output logic [7:0] data_o,
  output logic       frm_err_o,
  output logic       par_err_o,
  output logic       brk_o,
  output logic       busy_o
);
  frm_state_e      st_q, st_d;
  logic [OS_W-1:0] os_q, os_d;
  logic [2:0]      idx_q, idx_d, last_idx;
  logic [7:0]      sh_q, sh_d;
  logic [1:0]      vote_q, vote_d;
  logic            pacc_q, pacc_d, pbit_q, pbit_d, sidx_q, sidx_d, bad_q, bad_d;
  logic            bit_val, par_en, two_stop;

  always_comb begin
    par_en   = cfg_par_i[1];
    two_stop = cfg_stop_i[1];
    last_idx = 3'(cfg_dlen_i) + 3'd4;
    bit_val  = ({1'b0, vote_q} + {2'b00, line_i}) >= 3'd2;
    data_o   = sh_q >> (2'd3 - cfg_dlen_i);
    busy_o   = (st_q != ST_IDLE);
  end

  always_comb begin
    st_d = st_q; os_d = os_q; idx_d = idx_q; sh_d = sh_q; vote_d = vote_q;
    pacc_d = pacc_q; pbit_d = pbit_q; sidx_d = sidx_q; bad_d = bad_q;
    push_o = 1'b0; frm_err_o = 1'b0; par_err_o = 1'b0; brk_o = 1'b0;
    if (tick_i) begin
      case (st_q)
        ST_IDLE: begin
          if (!line_i) begin
            st_d = ST_START; os_d = '0; vote_d = '0; sh_d = '0; idx_d = '0;
            pacc_d = 1'b0; pbit_d = 1'b0; sidx_d = 1'b0; bad_d = 1'b0;
          end
        end
        ST_WAIT_HI: begin
          if (line_i) st_d = ST_IDLE;
        end
        default: begin
          os_d = os_q + 1'b1;
          if (os_q == OS_W'(VOTE_A) || os_q == OS_W'(VOTE_B))
            vote_d = vote_q + {1'b0, line_i};
          if (os_q == OS_W'(VOTE_C)) begin
            vote_d = '0;
            case (st_q)
              ST_START: if (bit_val) st_d = ST_IDLE;
              ST_DATA: begin
                sh_d   = {bit_val, sh_q[7:1]};
                pacc_d = pacc_q ^ bit_val;
              end
              ST_PAR:  pbit_d = bit_val;
              ST_STOP: if (!bit_val) bad_d = 1'b1;
              default: ;
            endcase
          end
          if (os_q == OS_W'(OS_RATE - 1)) begin
            case (st_q)
              ST_START: st_d = ST_DATA;
              ST_DATA: begin
                if (idx_q == last_idx) st_d = par_en ? ST_PAR : ST_STOP;
                else                   idx_d = idx_q + 1'b1;
              end
              ST_PAR: st_d = ST_STOP;
              ST_STOP: begin
                if (two_stop && !sidx_q) begin
                  sidx_d = 1'b1;
                end else if (bad_q && sh_q == '0 && !pbit_q) begin
                  brk_o = 1'b1;
                  st_d  = ST_WAIT_HI;
                end else begin
                  push_o    = 1'b1;
                  frm_err_o = bad_q;
                  par_err_o = par_en && ((pacc_q ^ pbit_q) != cfg_par_i[0]);
                  st_d      = bad_q ? ST_WAIT_HI : ST_IDLE;
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; os_q <= '0; idx_q <= '0; sh_q <= '0; vote_q <= '0;
      pacc_q <= 1'b0; pbit_q <= 1'b0; sidx_q <= 1'b0; bad_q <= 1'b0;
    end else begin
      st_q <= st_d; os_q <= os_d; idx_q <= idx_d; sh_q <= sh_d; vote_q <= vote_d;
      pacc_q <= pacc_d; pbit_q <= pbit_d; sidx_q <= sidx_d; bad_q <= bad_d;
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    do_push = push_i && !flush_i && (cnt_q != CW'(DEPTH));
    do_pop  = pop_i && !flush_i && (cnt_q != '0);
    wp_d = wp_q; rp_d = rp_q; cnt_d = cnt_q;
    if (flush_i) begin
      wp_d = '0; rp_d = '0; cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      wp_q <= wp_d; rp_q <= rp_d; cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  assign dout_o = mem[rp_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/serial_rx_hub.sv
module serial_rx_hub
  import srx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int TOUT_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              lb_en_i,
  input  logic              lb_tx_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [1:0]        cfg_dlen_i,
  input  logic [1:0]        cfg_par_i,
  input  logic [1:0]        cfg_stop_i,
  input  logic [CNT_W-1:0]  cfg_full_thr_i,
  input  logic              cfg_flow_en_i,
  input  logic [CNT_W-1:0]  cfg_flow_thr_i,
  input  logic              cfg_tout_en_i,
  input  logic [TOUT_W-1:0] cfg_tout_thr_i,
  input  logic              cfg_fifo_rst_i,
  input  logic              pop_i,
  output logic [7:0]        pop_data_o,
  output logic [CNT_W-1:0]  fifo_cnt_o,
  output logic              rts_o,
  input  logic [IRQ_N-1:0]  int_ena_i,
  input  logic [IRQ_N-1:0]  int_clr_i,
  output logic [IRQ_N-1:0]  int_raw_o,
  output logic [IRQ_N-1:0]  int_st_o,
  output logic              irq_o
);
  localparam int UNIT_TICKS = OS_RATE * UNIT_BITS;
  localparam int SUB_W      = $clog2(UNIT_TICKS);

  logic [1:0]        rs_q;
  logic              rst_s_n, tick, line, push, frm_err, par_err, brk, busy;
  logic [7:0]        rx_byte;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [TOUT_W-1:0] unit_q, unit_d;
  logic              nonempty, unit_done, tout_hit;
  logic [IRQ_N-1:0]  ev, raw_q, raw_d;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  srx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .div_i(cfg_div_i), .tick_o(tick));

  srx_line #(.STAGES(2)) u_line (
    .clk(clk), .rst_n(rst_s_n), .rx_i(rx_i), .lb_en_i(lb_en_i),
    .lb_i(lb_tx_i), .line_o(line));

  srx_framer u_frm (
    .clk(clk), .rst_n(rst_s_n), .tick_i(tick), .line_i(line),
    .cfg_dlen_i(cfg_dlen_i), .cfg_par_i(cfg_par_i), .cfg_stop_i(cfg_stop_i),
    .push_o(push), .data_o(rx_byte), .frm_err_o(frm_err), .par_err_o(par_err),
    .brk_o(brk), .busy_o(busy));

  srx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_s_n), .flush_i(cfg_fifo_rst_i), .push_i(push),
    .din_i(rx_byte), .pop_i(pop_i), .dout_o(pop_data_o), .cnt_o(fifo_cnt_o));

  // idle timeout in units of UNIT_BITS bit periods
  always_comb begin
    nonempty  = (fifo_cnt_o != '0);
    unit_done = (unit_q >= cfg_tout_thr_i);
    tout_hit  = cfg_tout_en_i && (cfg_tout_thr_i != '0) && nonempty && unit_done && !busy;
    sub_d  = sub_q;
    unit_d = unit_q;
    if (!nonempty || busy) begin
      sub_d  = '0;
      unit_d = '0;
    end else if (tick && !unit_done) begin
      if (sub_q == SUB_W'(UNIT_TICKS - 1)) begin
        sub_d  = '0;
        unit_d = unit_q + 1'b1;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_comb begin
    ev           = '0;
    ev[IRQ_FULL] = (cfg_full_thr_i != '0) && (fifo_cnt_o >= cfg_full_thr_i);
    ev[IRQ_TOUT] = tout_hit;
    ev[IRQ_FRM]  = frm_err;
    ev[IRQ_PAR]  = par_err;
    ev[IRQ_BRK]  = brk;
    raw_d        = (raw_q & ~int_clr_i) | ev;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sub_q  <= '0;
      unit_q <= '0;
      raw_q  <= '0;
    end else begin
      sub_q  <= sub_d;
      unit_q <= unit_d;
      raw_q  <= raw_d;
    end
  end

  assign int_raw_o = raw_q;
  assign int_st_o  = raw_q & int_ena_i;
  assign irq_o     = |int_st_o;
  assign rts_o     = !(cfg_flow_en_i && (fifo_cnt_o >= cfg_flow_thr_i));
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
  parameter int CNT_W = 5,
  parameter int IRQ_N = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] fifo_cnt_o,
  input logic             pop_i,
  input logic             cfg_fifo_rst_i,
  input logic             cfg_flow_en_i,
  input logic             rts_o,
  input logic             irq_o,
  input logic [IRQ_N-1:0] int_st_o,
  input logic [IRQ_N-1:0] int_raw_o,
  input logic [IRQ_N-1:0] int_clr_i
);
  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fifo_rst_i |=> (fifo_cnt_o == '0));

  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt_o == '0 && pop_i) |=> (fifo_cnt_o <= CNT_W'(1)));

  // R1
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt_o > $past(fifo_cnt_o)) |-> (fifo_cnt_o == $past(fifo_cnt_o) + 1'b1));

  // R9
  rts_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flow_en_i |-> rts_o);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(int_raw_o) & ~$past(int_clr_i)) & ~int_raw_o) == '0));

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (int_st_o != '0));
endmodule

bind serial_rx_hub srx_chk #(.CNT_W(CNT_W), .IRQ_N(srx_pkg::IRQ_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_cnt_o(fifo_cnt_o), .pop_i(pop_i),
  .cfg_fifo_rst_i(cfg_fifo_rst_i), .cfg_flow_en_i(cfg_flow_en_i), .rts_o(rts_o),
  .irq_o(irq_o), .int_st_o(int_st_o), .int_raw_o(int_raw_o), .int_clr_i(int_clr_i));

// File: tb/sim_serial_rx_hub.sv
module sim_serial_rx_hub;
  localparam int DIV_W = 16;
  localparam int DEPTH = 16;
  localparam int TOUT_W = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic tx_line = 1'b1, lb_sel = 1'b0;
  logic rx_i, lb_tx_i;
  logic [DIV_W-1:0] cfg_div = 16'd4;
  logic [1:0] cfg_dlen = 2'd3, cfg_par = 2'd0, cfg_stop = 2'd1;
  logic [CW-1:0] full_thr = '0, flow_thr = '0;
  logic flow_en = 1'b0, tout_en = 1'b0, fifo_rst = 1'b0, pop_i = 1'b0;
  logic [TOUT_W-1:0] tout_thr = '0;
  logic [4:0] ena = 5'h1F, clr = 5'h00;
  logic [7:0] pop_data;
  logic [CW-1:0] cnt;
  logic rts, irq;
  logic [4:0] raw, st;

  assign rx_i    = lb_sel ? 1'b0 : tx_line;
  assign lb_tx_i = lb_sel ? tx_line : 1'b1;

  serial_rx_hub #(.DIV_W(DIV_W), .FIFO_DEPTH(DEPTH), .TOUT_W(TOUT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .lb_en_i(lb_sel), .lb_tx_i(lb_tx_i),
    .cfg_div_i(cfg_div), .cfg_dlen_i(cfg_dlen), .cfg_par_i(cfg_par), .cfg_stop_i(cfg_stop),
    .cfg_full_thr_i(full_thr), .cfg_flow_en_i(flow_en), .cfg_flow_thr_i(flow_thr),
    .cfg_tout_en_i(tout_en), .cfg_tout_thr_i(tout_thr), .cfg_fifo_rst_i(fifo_rst),
    .pop_i(pop_i), .pop_data_o(pop_data), .fifo_cnt_o(cnt), .rts_o(rts),
    .int_ena_i(ena), .int_clr_i(clr), .int_raw_o(raw), .int_st_o(st), .irq_o(irq));

  int checks = 0, errors = 0, bitc = 64;
  bit mon_en = 1'b0, done = 1'b0;
  string cur_tag = "R2";
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops the FIFO and compares against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (pop_i) pop_i = 1'b0;
      else if (mon_en && cnt != '0) begin
        if (exp_q.size() == 0) chk(1'b0, {cur_tag, " unexpected byte"}, pop_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(pop_data == e, {cur_tag, " data"}, pop_data, e);
        end
        pop_i = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input bit v);
    tx_line = v;
    wait_n(bitc);
  endtask

  // driver: sends one frame and records the expected byte
  task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit podd,
                      input bit bad_par, input bit s1, input bit s2, input int ns, input bit keep);
    logic [7:0] m;
    bit p;
    m = 8'((1 << nb) - 1);
    if (keep) exp_q.push_back(d & m);
    p = (^(d & m)) ^ podd ^ bad_par;
    drive(1'b0);
    for (int i = 0; i < nb; i++) drive(d[i]);
    if (pen) drive(p);
    drive(s1);
    if (ns == 2) drive(s2);
    tx_line = 1'b1;
    wait_n(2 * bitc);
  endtask

  task automatic send8(input logic [7:0] d, input bit keep);
    send(d, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1, keep);
  endtask

  task automatic drain(input string tag);
    int n = 0;
    mon_en = 1'b1;
    while ((exp_q.size() != 0 || cnt != '0) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    wait_n(4);
    chk(exp_q.size() == 0 && cnt == '0, {tag, " drain"}, exp_q.size(), 0);
    mon_en = 1'b0;
  endtask

  task automatic w1c(input logic [4:0] m);
    clr = m;
    wait_n(1);
    clr = 5'h00;
    wait_n(1);
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    // reset state
    chk(cnt == '0, "R11 reset count", cnt, 0);
    chk(raw == '0 && irq == 1'b0, "R10 reset status", raw, 0);
    chk(rts == 1'b1, "R9 reset rts", rts, 1);

    // R1: count moves only after the stop bit
    fork
      send8(8'hA5, 1'b1);
      begin
        wait_n(bitc * 9 + bitc / 2);
        chk(cnt == '0, "R1 count at stop centre", cnt, 0);
        wait_n(bitc / 2 + 24);
        chk(cnt == CW'(1), "R1 count after stop", cnt, 1);
      end
    join
    cur_tag = "R1";
    drain("R1");

    // R2: data lengths
    cur_tag = "R2";
    mon_en = 1'b1;
    send8(8'h3C, 1'b1);
    send8(8'hFF, 1'b1);
    send8(8'h00, 1'b1);
    cfg_dlen = 2'd0;
    send(8'h1B, 5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1, 1'b1);
    cfg_dlen = 2'd2;
    send(8'h55, 7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1, 1'b1);
    cfg_dlen = 2'd3;
    drain("R2");

    // R3: parity
    cur_tag = "R3";
    mon_en = 1'b1;
    cfg_par = 2'b11;
    send(8'h37, 8, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b1);
    chk(raw[3] == 1'b0, "R3 odd good", raw[3], 0);
    send(8'h37, 8, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1, 1'b1);
    chk(raw[3] == 1'b1, "R3 odd bad", raw[3], 1);
    w1c(5'b01000);
    chk(raw[3] == 1'b0, "R10 w1c parity", raw[3], 0);
    cfg_par = 2'b10;
    send(8'hC1, 8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1, 1'b1);
    chk(raw[3] == 1'b0, "R3 even good", raw[3], 0);
    send(8'hC1, 8, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1, 1'b1);
    chk(raw[3] == 1'b1, "R3 even bad", raw[3], 1);
    cfg_par = 2'b00;
    drain("R3");
    w1c(5'h1F);

    // R4: stop bits
    cur_tag = "R4";
    mon_en = 1'b1;
    cfg_stop = 2'd3;
    send(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1'b1);
    chk(raw[2] == 1'b0, "R4 two stops good", raw[2], 0);
    send(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2, 1'b1);
    chk(raw[2] == 1'b1, "R4 second stop low", raw[2], 1);
    w1c(5'b00100);
    cfg_stop = 2'd1;
    send(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1, 1'b1);
    chk(raw[2] == 1'b1, "R4 single stop low", raw[2], 1);
    drain("R4");
    w1c(5'h1F);

    // R5: break
    cur_tag = "R5";
    mon_en = 1'b1;
    tx_line = 1'b0;
    wait_n(12 * bitc);
    tx_line = 1'b1;
    wait_n(3 * bitc);
    chk(raw[4] == 1'b1, "R5 break flag", raw[4], 1);
    chk(raw[2] == 1'b0, "R5 not framing", raw[2], 0);
    chk(cnt == '0 && exp_q.size() == 0, "R5 nothing stored", cnt, 0);
    w1c(5'h1F);

    // R6: glitch rejection and divider
    cur_tag = "R6";
    tx_line = 1'b0;
    wait_n(20);
    tx_line = 1'b1;
    wait_n(12 * bitc);
    chk(cnt == '0 && raw == '0, "R6 glitch ignored", raw, 0);
    cfg_div = 16'd2;
    bitc = 32;
    send8(8'hC3, 1'b1);
    drain("R6");
    cfg_div = 16'd4;
    bitc = 64;

    // R7 / R9 / R10: thresholds and mask
    cur_tag = "R7";
    full_thr = CW'(3);
    flow_en = 1'b1;
    flow_thr = CW'(2);
    send8(8'h11, 1'b1);
    chk(rts == 1'b1, "R9 rts below", rts, 1);
    send8(8'h22, 1'b1);
    chk(rts == 1'b0, "R9 rts at level", rts, 0);
    chk(raw[0] == 1'b0, "R7 below full", raw[0], 0);
    tout_en = 1'b1;
    tout_thr = 8'd2;
    send8(8'h33, 1'b1);
    chk(raw[0] == 1'b1, "R7 at full", raw[0], 1);
    chk(irq == 1'b1, "R10 irq on", irq, 1);
    ena = 5'h00;
    wait_n(1);
    chk(irq == 1'b0 && st == '0, "R10 masked", st, 0);
    ena = 5'h1F;

    // R8: timeout window
    cur_tag = "R8";
    wait_n(400);
    chk(raw[1] == 1'b0, "R8 before window", raw[1], 0);
    wait_n(700);
    chk(raw[1] == 1'b1, "R8 after window", raw[1], 1);
    full_thr = '0;
    drain("R8");
    chk(rts == 1'b1, "R9 rts after drain", rts, 1);
    w1c(5'h1F);
    wait_n(1500);
    chk(raw[1] == 1'b0, "R8 empty no timeout", raw[1], 0);
    tout_en = 1'b0;
    flow_en = 1'b0;

    // R11: flush
    cur_tag = "R11";
    send8(8'h44, 1'b0);
    send8(8'h45, 1'b0);
    chk(cnt == CW'(2), "R11 filled", cnt, 2);
    fifo_rst = 1'b1;
    wait_n(2);
    chk(cnt == '0, "R11 flushed", cnt, 0);
    send8(8'h46, 1'b0);
    chk(cnt == '0, "R11 dropped while held", cnt, 0);
    fifo_rst = 1'b0;
    wait_n(2);

    // R12: loopback
    cur_tag = "R12";
    lb_sel = 1'b1;
    wait_n(2 * bitc);
    mon_en = 1'b1;
    send8(8'h6E, 1'b1);
    drain("R12");
    chk(raw[4] == 1'b0, "R12 rx ignored", raw[4], 0);
    lb_sel = 1'b0;

    finish_run();
  end
endmodule